// File: doc/BRIEF.md
# Serial audio frame transceiver

This block is a full-duplex serial port for PCM audio. A bit clock and a frame sync arrive from outside. The transmit half takes parallel words from a holding register and shifts them out, most significant bit first, on a serial data line. The receive half assembles words from a second serial line and presents them in a parallel register. Each direction has a ready flag, a one-cycle event pulse for a DMA engine or processor, and a sticky error flag.

Both lines are oversampled by the system clock. The edges of the bit clock are found by comparing it with a registered copy. Each direction has its own settings:
- word length, chosen from a coded set;
- data delay after the frame sync;
- clock polarity and frame-sync polarity;
- an enable that holds the direction in reset while low.

The frame length, a count of words, is shared by both directions. A frame of two words carries the left and right samples of a stereo pair.

Top module: `serial_audio_port`

## Requirements
- R1: The word-length code selects the bits per word: 0=8, 1=12, 2=16, 3=20, 4=24, 5=32, and codes 6 and 7 also give 32. Words are right-aligned in `tx_wdata` and `rx_data`, sent most significant bit first, and the unused upper bits of `rx_data` read as zero.
- R2: `frm_len` holds the number of words per frame minus one. The words of a frame follow one another with no idle bit between them. After the last bit of the frame the transmit line returns to 0.
- R3: With a delay value D, the first data bit is in the bit period D periods after the one in which the frame sync is first seen active. A delay value of 0 acts as 1. Until the first data bit, the transmit line is 0.
- R4: With clock polarity 0, the transmitter launches on the falling edge of `bclk` and the receiver samples on the rising edge. Polarity 1 swaps these edges. With frame-sync polarity 0, `fsync` is active high; with 1 it is active low. A frame starts at an inactive-to-active transition seen on a sampling edge.
- R5: When a received word completes, it is written to `rx_data`, `rx_rdy` rises, and `rx_evt` pulses for one cycle. A one-cycle `rx_rd` clears `rx_rdy`.
- R6: A word that completes while `rx_rdy` is still set, with no read in that cycle, sets the sticky `rx_ovr`. The new word replaces the old one in `rx_data`.
- R7: At the start of each transmit word, the holding register is copied into the shifter, `tx_rdy` rises, and `tx_evt` pulses for one cycle. A `tx_wr` stores `tx_wdata` and clears `tx_rdy`. If the holding register is empty at a word start, the word is sent as zeros and the sticky `tx_urun` is set.
- R8: With `tx_fsig` set, a frame-sync transition that arrives during a transmit frame is ignored, and the frame continues unchanged.
- R9: While `tx_en` is low, `tx_sd` is 0, `tx_evt` stays low, `tx_rdy` is 1, `tx_urun` is cleared and writes are dropped. While `rx_en` is low, `rx_evt`, `rx_rdy` and `rx_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial signals |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| tx_wlen | input | 3 | Transmit word-length code |
| rx_wlen | input | 3 | Receive word-length code |
| frm_len | input | FRM_W | Words per frame minus one |
| tx_dly | input | DLY_W | Transmit data delay in bit periods |
| rx_dly | input | DLY_W | Receive data delay in bit periods |
| tx_cpol | input | 1 | Transmit clock polarity |
| tx_fpol | input | 1 | Transmit frame-sync polarity |
| rx_cpol | input | 1 | Receive clock polarity |
| rx_fpol | input | 1 | Receive frame-sync polarity |
| tx_fsig | input | 1 | Ignore frame sync during a transmit frame |
| tx_en | input | 1 | Transmit enable; low holds the transmitter in reset |
| rx_en | input | 1 | Receive enable; low holds the receiver in reset |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 32 | Transmit word, right-aligned |
| tx_rdy | output | 1 | Transmit holding register is empty |
| tx_evt | output | 1 | One-cycle pulse at each transmit word start |
| tx_urun | output | 1 | Sticky transmit underrun |
| tx_sd | output | 1 | Transmit serial data |
| rx_sd | input | 1 | Receive serial data |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 32 | Received word, right-aligned |
| rx_rdy | output | 1 | Receive register holds an unread word |
| rx_evt | output | 1 | One-cycle pulse when a received word completes |
| rx_ovr | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with its default parameters: a 3-bit frame length and a 2-bit delay field. This allows frames of one, two and four words and delays of 0 through 3, so the clamp of delay 0 to 1 and the longest delay are both tested. The transmit line is looped back to the receive line. Every word-length code, including an unused code, and all four polarity combinations are run through this loop, and the model predicts every bit period of the line. Underrun, overrun, an ignored mid-frame frame sync, and a transmitter held in reset each have their own frame.

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int FRM_W = 3,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  input  logic [2:0]       tx_wlen,
  input  logic [2:0]       rx_wlen,
  input  logic [FRM_W-1:0] frm_len,
  input  logic [DLY_W-1:0] tx_dly,
  input  logic [DLY_W-1:0] rx_dly,
  input  logic             tx_cpol,
  input  logic             tx_fpol,
  input  logic             rx_cpol,
  input  logic             rx_fpol,
  input  logic             tx_fsig,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_wr,
  input  logic [31:0]      tx_wdata,
  output logic             tx_rdy,
  output logic             tx_evt,
  output logic             tx_urun,
  output logic             tx_sd,
  input  logic             rx_sd,
  input  logic             rx_rd,
  output logic [31:0]      rx_data,
  output logic             rx_rdy,
  output logic             rx_evt,
  output logic             rx_ovr
);
  localparam int DW = 32;
  localparam int BW = $clog2(DW);

  function automatic logic [BW:0] wbits(input logic [2:0] c);
    case (c)
      3'd0: return (BW+1)'(8);
      3'd1: return (BW+1)'(12);
      3'd2: return (BW+1)'(16);
      3'd3: return (BW+1)'(20);
      3'd4: return (BW+1)'(24);
      default: return (BW+1)'(32);
    endcase
  endfunction

  logic bclk_q;
  always_ff @(posedge clk) bclk_q <= rst_n ? bclk : 1'b0;

  // transmit side
  logic [BW:0]      tl;
  logic [DLY_W-1:0] td;
  logic             tx_smp, tx_lch, tx_fs;
  logic             t_fsq, t_busy, t_wait, t_full, t_start, t_load;
  logic [DLY_W-1:0] t_dc;
  logic [BW-1:0]    t_bc;
  logic [FRM_W-1:0] t_wc;
  logic [DW-1:0]    t_sh, t_hold;

  assign tl      = wbits(tx_wlen);
  assign td      = (tx_dly == '0) ? DLY_W'(1) : tx_dly;
  assign tx_smp  = ((bclk ^ tx_cpol) & ~(bclk_q ^ tx_cpol));
  assign tx_lch  = (~(bclk ^ tx_cpol) & (bclk_q ^ tx_cpol));
  assign tx_fs   = fsync ^ tx_fpol;
  assign t_start = tx_smp & tx_fs & ~t_fsq & ~(t_busy & tx_fsig);
  assign t_load  = tx_lch & t_busy &
                   ((t_wait & (t_dc == DLY_W'(1))) | (~t_wait & (t_bc == '0) & (t_wc != '0)));
  assign tx_sd   = t_sh[DW-1];
  assign tx_rdy  = ~t_full;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      t_fsq <= 1'b0; t_busy <= 1'b0; t_wait <= 1'b0; t_full <= 1'b0;
      t_dc <= '0; t_bc <= '0; t_wc <= '0; t_sh <= '0; t_hold <= '0;
      tx_evt <= 1'b0; tx_urun <= 1'b0;
    end else begin
      tx_evt <= t_load;
      if (tx_smp) t_fsq <= tx_fs;
      if (t_start) begin
        t_busy <= 1'b1; t_wait <= 1'b1; t_dc <= td; t_wc <= frm_len; t_sh <= '0;
      end else if (tx_lch && t_busy) begin
        if (t_wait) begin
          if (t_dc == DLY_W'(1)) t_wait <= 1'b0;
          else t_dc <= t_dc - 1'b1;
        end else if (t_bc != '0) begin
          t_sh <= t_sh << 1;
          t_bc <= t_bc - 1'b1;
        end else if (t_wc != '0) begin
          t_wc <= t_wc - 1'b1;
        end else begin
          t_busy <= 1'b0;
          t_sh <= '0;
        end
      end
      if (t_load) begin
        t_sh <= t_full ? (t_hold << (DW - int'(tl))) : '0;
        t_bc <= BW'(tl - 1'b1);
        t_full <= 1'b0;
        if (!t_full) tx_urun <= 1'b1;
      end
      if (tx_wr) begin
        t_hold <= tx_wdata;
        t_full <= 1'b1;
      end
    end
  end

  // receive side
  logic [BW:0]      rl;
  logic [DLY_W-1:0] rd;
  logic             rx_smp, rx_fs;
  logic             r_fsq, r_busy, r_start, r_take, r_done;
  logic [DLY_W-1:0] r_dc;
  logic [BW-1:0]    r_bc;
  logic [FRM_W-1:0] r_wc;
  logic [DW-1:0]    r_sh, r_nsh, r_mask;

  assign rl      = wbits(rx_wlen);
  assign rd      = (rx_dly == '0) ? DLY_W'(1) : rx_dly;
  assign rx_smp  = ((bclk ^ rx_cpol) & ~(bclk_q ^ rx_cpol));
  assign rx_fs   = fsync ^ rx_fpol;
  assign r_start = rx_smp & rx_fs & ~r_fsq;
  assign r_take  = rx_smp & r_busy & ~r_start & (r_dc == '0);
  assign r_done  = r_take & (r_bc == BW'(rl - 1'b1));
  assign r_nsh   = {r_sh[DW-2:0], rx_sd};
  assign r_mask  = ~({DW{1'b1}} << rl);

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      r_fsq <= 1'b0; r_busy <= 1'b0; r_dc <= '0; r_bc <= '0; r_wc <= '0;
      r_sh <= '0; rx_data <= '0; rx_rdy <= 1'b0; rx_evt <= 1'b0; rx_ovr <= 1'b0;
    end else begin
      rx_evt <= r_done;
      if (rx_smp) r_fsq <= rx_fs;
      if (r_start) begin
        r_busy <= 1'b1; r_dc <= rd - 1'b1; r_bc <= '0; r_wc <= '0;
      end else if (rx_smp && r_busy) begin
        if (r_dc != '0) r_dc <= r_dc - 1'b1;
        else begin
          r_sh <= r_nsh;
          if (r_done) begin
            r_bc <= '0;
            if (r_wc == frm_len) r_busy <= 1'b0;
            else r_wc <= r_wc + 1'b1;
          end else r_bc <= r_bc + 1'b1;
        end
      end
      if (rx_rd) rx_rdy <= 1'b0;
      if (r_done) begin
        rx_data <= r_nsh & r_mask;
        rx_rdy <= 1'b1;
        if (rx_rdy && !rx_rd) rx_ovr <= 1'b1;
      end
    end
  end

  p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!tx_sd && !tx_evt && tx_rdy && !tx_urun));
  p_rx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_evt && !rx_rdy && !rx_ovr));
  p_evt_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> rx_rdy);
  p_read_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> (!rx_rdy || rx_evt));
  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> rx_evt);
  p_urun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_urun) |-> tx_evt);
  p_evt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> !tx_evt);
endmodule

// File: tb/serial_audio_port_test.sv
module serial_audio_port_test;
  localparam int H = 4;
  logic clk = 0, rst_n = 0;
  logic bclk = 1, fsync = 0;
  logic [2:0] tx_wlen = 0, rx_wlen = 0;
  logic [2:0] frm_len = 1;
  logic [1:0] tx_dly = 1, rx_dly = 1;
  logic tx_cpol = 0, tx_fpol = 0, rx_cpol = 0, rx_fpol = 0, tx_fsig = 0;
  logic tx_en = 0, rx_en = 0, tx_wr = 0, rx_rd = 0;
  logic [31:0] tx_wdata = 0, rx_data;
  logic tx_rdy, tx_evt, tx_urun, tx_sd, rx_rdy, rx_evt, rx_ovr;

  int checks = 0, errors = 0, evn = 0;
  bit rd_on = 1;
  logic [31:0] txq[$], rxq[$];
  logic [31:0] last_w;

  always #5 clk = ~clk;

  serial_audio_port uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .tx_wlen(tx_wlen), .rx_wlen(rx_wlen), .frm_len(frm_len),
    .tx_dly(tx_dly), .rx_dly(rx_dly), .tx_cpol(tx_cpol), .tx_fpol(tx_fpol),
    .rx_cpol(rx_cpol), .rx_fpol(rx_fpol), .tx_fsig(tx_fsig),
    .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .tx_rdy(tx_rdy), .tx_evt(tx_evt), .tx_urun(tx_urun), .tx_sd(tx_sd),
    .rx_sd(tx_sd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_rdy(rx_rdy),
    .rx_evt(rx_evt), .rx_ovr(rx_ovr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbits(input int c);
    case (c) 0: return 8; 1: return 12; 2: return 16; 3: return 20; 4: return 24; default: return 32; endcase
  endfunction

  always @(posedge clk) if (tx_evt) evn++;

  initial forever begin
    @(negedge clk);
    tx_wr = 0;
    if (tx_en && tx_rdy && txq.size() > 0) begin
      tx_wdata = txq.pop_front();
      tx_wr = 1;
    end
  end

  initial forever begin
    @(negedge clk);
    rx_rd = 0;
    if (rd_on && rx_rdy) begin
      if (rxq.size() == 0) chk(0, "R5 unexpected word", rx_data, 0);
      else begin
        logic [31:0] e;
        e = rxq.pop_front();
        chk(rx_data == e, "R5 received word", rx_data, e);
      end
      rx_rd = 1;
    end
  end

  task automatic cfg(input int code, input int d, input int frm, input bit cp, input bit fp,
                     input bit ig, input bit ten, input bit ren);
    @(negedge clk);
    tx_en = 0; rx_en = 0;
    tx_wlen = 3'(code); rx_wlen = 3'(code); tx_dly = 2'(d); rx_dly = 2'(d);
    frm_len = 3'(frm); tx_cpol = cp; rx_cpol = cp; tx_fpol = fp; rx_fpol = fp; tx_fsig = ig;
    bclk = !cp; fsync = fp;
    repeat (3) @(negedge clk);
    tx_en = ten; rx_en = ren;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input int nw, input int code, input int d, input int mid,
                           input bit feed, input bit rxexp, input string tag);
    int L, de, tot, e0;
    logic [31:0] lw[8];
    logic [31:0] w, m;
    L = nbits(code);
    de = (d == 0) ? 1 : d;
    m = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 1);
    for (int i = 0; i < nw; i++) begin
      w = $urandom() & m;
      lw[i] = (feed && tx_en) ? w : 32'd0;
      if (feed && tx_en) txq.push_back(w);
      if (rxexp) rxq.push_back(lw[i]);
      last_w = lw[i];
    end
    repeat (3) @(negedge clk);
    e0 = evn;
    tot = de + nw * L + 1;
    for (int s = 0; s < tot; s++) begin
      logic ex;
      bclk = tx_cpol;
      fsync = ((s == 0) || (s == mid)) ^ tx_fpol;
      repeat (H) @(negedge clk);
      bclk = !tx_cpol;
      repeat (H) @(negedge clk);
      if (s < de || s >= de + nw * L) ex = 1'b0;
      else ex = lw[(s - de) / L][L - 1 - ((s - de) % L)];
      chk(tx_sd == ex, tag, {31'd0, tx_sd}, {31'd0, ex});
    end
    repeat (4) @(negedge clk);
    if (rxexp) chk(rxq.size() == 0, "R5 all words delivered", rxq.size(), 0);
    chk(evn - e0 == (tx_en ? nw : 0), "R7 tx event count", evn - e0, tx_en ? nw : 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(tx_sd == 0 && tx_rdy == 1 && tx_evt == 0, "R9 reset tx state", {tx_sd, tx_rdy, tx_evt}, 3'b010);
    chk(rx_rdy == 0 && rx_ovr == 0 && tx_urun == 0, "R9 reset flags", {rx_rdy, rx_ovr, tx_urun}, 0);

    for (int c = 0; c < 6; c++) begin
      cfg(c, 1, 1, c[0], c[1], 0, 1, 1);
      run_frame(2, c, 1, -1, 1, 1, "R1 word length line bit");
    end
    cfg(6, 1, 1, 0, 0, 0, 1, 1);
    run_frame(2, 6, 1, -1, 1, 1, "R1 spare code as 32 bits");

    for (int p = 0; p < 4; p++) begin
      cfg(2, 1, 1, p[0], p[1], 0, 1, 1);
      run_frame(2, 2, 1, -1, 1, 1, "R4 polarity line bit");
    end

    cfg(2, 2, 1, 0, 0, 0, 1, 1);
    run_frame(2, 2, 2, -1, 1, 1, "R3 delay 2");
    cfg(1, 3, 1, 1, 0, 0, 1, 1);
    run_frame(2, 1, 3, -1, 1, 1, "R3 delay 3");
    cfg(0, 0, 1, 0, 1, 0, 1, 1);
    run_frame(2, 0, 0, -1, 1, 1, "R3 delay 0 acts as 1");

    cfg(0, 1, 3, 0, 0, 0, 1, 1);
    run_frame(4, 0, 1, -1, 1, 1, "R2 four-word frame");
    cfg(3, 1, 0, 0, 0, 0, 1, 1);
    run_frame(1, 3, 1, -1, 1, 1, "R2 one-word frame");

    cfg(0, 1, 1, 0, 0, 0, 1, 1);
    chk(tx_urun == 0, "R7 no underrun before", tx_urun, 0);
    run_frame(2, 0, 1, -1, 0, 1, "R7 underrun sends zeros");
    chk(tx_urun == 1, "R7 underrun flag", tx_urun, 1);

    rd_on = 0;
    cfg(2, 1, 1, 0, 0, 0, 1, 1);
    run_frame(2, 2, 1, -1, 1, 0, "R6 line during overrun");
    chk(rx_ovr == 1, "R6 overrun flag", rx_ovr, 1);
    chk(rx_rdy == 1, "R6 ready still set", rx_rdy, 1);
    chk(rx_data == last_w, "R6 newest word kept", rx_data, last_w);
    cfg(2, 1, 1, 0, 0, 0, 1, 1);
    chk(rx_ovr == 0 && rx_rdy == 0, "R9 rx reset clears flags", {rx_ovr, rx_rdy}, 0);
    rd_on = 1;

    cfg(2, 1, 1, 0, 0, 1, 1, 0);
    run_frame(2, 2, 1, 6, 1, 0, "R8 mid-frame sync ignored");
    chk(rx_rdy == 0 && rx_evt == 0, "R9 rx held in reset", {rx_rdy, rx_evt}, 0);

    cfg(1, 1, 1, 0, 0, 0, 0, 1);
    @(negedge clk); tx_wdata = 32'hABC; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    chk(tx_rdy == 1, "R9 write dropped in reset", tx_rdy, 1);
    run_frame(2, 1, 1, -1, 1, 1, "R9 tx held in reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule